// File: doc/BRIEF.md
# Interrupt and Pin Wake-up Controller

This block sits beside a small processor core and decides when the core is interrupted and when a sleeping chip is woken. It has two interrupt sources: a timer-overflow pulse from the timer, and a falling edge on pin 0 of a four-pin input port. Any of the four pins can also wake the chip from sleep on a falling edge. Three software-visible control registers live here: a wake-up control register, an interrupt mask register and an interrupt flag register. The core reads and writes them through a simple select/write-enable port. The block also produces the effective watchdog enable from a configuration bit and a software bit.

The core raises `irq_ack` in the cycle it takes the request. The global enable is cleared at that edge, so no second interrupt can be taken before `reti` sets the global enable again. Interrupts are only requested in advanced mode, and they always point at the fixed vector on `irq_vector`. A flag raised while the chip sleeps is held back until the chip is awake. It survives a wake-up caused by a pin. It is discarded when the reset controller reports, with `warm_wake`, that the chip woke for another reason.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, and `irq_req`, `wake_req` and `wdt_run` are low.
- R2: Register select codes are 0 = wake-up control, 1 = interrupt mask, 2 = interrupt flag, 3 = none (reads 0x00). Reads are combinational. In the wake-up register, bits 7, 6, 5 and 3..0 are writable and bit 4 reads 0. In the mask register, only bits 7, 2 and 0 are writable and the others read 0.
- R3: `wdt_run` is high exactly when `cfg_wdt_en` is high and wake-up register bit 7 is set.
- R4: While `asleep` is high, a falling edge on pin n (n = 0..3) raises `wake_req` for exactly one cycle, but only if wake-up register bit 6 and bit n are both set. Otherwise `wake_req` stays low.
- R5: A falling edge on pin 0 sets flag bit 2 only when wake-up register bit 5 and bit 0 are both set. Edges on pins 1..3 never set it.
- R6: A one-cycle `tmr_ovf` pulse sets flag bit 0.
- R7: Writing 1 to a flag bit has no effect, and writing 0 clears it. If a hardware set and a software clear of the same bit fall in one cycle, the bit ends up set.
- R8: `irq_req` is high exactly when `adv_mode` is high, mask bit 7 is set, `asleep` is low, and (flag bit 2 and mask bit 2) or (flag bit 0 and mask bit 0) holds. `irq_vector` is 0x7FE.
- R9: `irq_ack` clears mask bit 7 at the same clock edge. `reti` sets mask bit 7.
- R10: A flag raised while asleep survives a pin wake-up and then requests an interrupt once `asleep` falls. A `warm_wake` pulse while asleep clears the flags raised during that sleep, but keeps the flags raised before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_mode | input | 1 | Advanced mode; interrupts are requested only when high |
| cfg_wdt_en | input | 1 | Configuration watchdog enable (has priority) |
| asleep | input | 1 | Chip is in sleep |
| pin_a | input | 4 | Asynchronous port pins 3..0 |
| tmr_ovf | input | 1 | Timer overflow pulse |
| irq_ack | input | 1 | Core takes the interrupt this cycle |
| reti | input | 1 | Return-from-interrupt executed |
| warm_wake | input | 1 | Chip woke by reset or watchdog, not by a pin |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Selected register contents |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 11 | Interrupt vector address |
| wake_req | output | 1 | Wake-from-sleep request |
| wdt_run | output | 1 | Effective watchdog enable |

## Verification
The bench sweeps every combination of pin, per-pin enable, wake-up enable and pin-0 interrupt select, and counts the `wake_req` pulses and the external flag. A design that forgot a gating term would wake or flag on a masked pin. A design that re-fired on the held level would show more than one pulse. A collision between a timer set and a software clear checks that the set wins, and a write of ones checks that a flag cannot be forced on. The sleep tests check two cases. A design that ignored the sleep origin of a flag would either drop a flag raised before sleep or keep one raised during a watchdog wake.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int WK_WDT = 7;
  localparam int WK_WUE = 6;
  localparam int WK_EIS = 5;
  localparam int MK_GIE = 7;
  localparam int MK_EXT = 2;
  localparam int MK_TMR = 0;
  localparam int FL_EXT = 2;
  localparam int FL_TMR = 0;

  typedef enum logic [1:0] {
    SEL_WAKE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_fall_det.sv
module pin_fall_det #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] fall_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign fall_o[i] = prev_q & ~sync_q;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_wake_pkg::*;
#(
  parameter int NPIN = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_mode,
  input  logic            cfg_wdt_en,
  input  logic            asleep,
  input  logic [NPIN-1:0] pin_fall,
  input  logic            tmr_ovf,
  input  logic            irq_ack,
  input  logic            reti,
  input  logic            warm_wake,
  input  logic            sw_wr_en,
  input  logic [1:0]      sw_sel,
  input  logic [DW-1:0]   sw_wdata,
  output logic [DW-1:0]   sw_rdata,
  output logic            irq_req,
  output logic            wake_req,
  output logic            wdt_run
);
  localparam logic [DW-1:0] WAKE_W = DW'((1 << WK_WDT) | (1 << WK_WUE) | (1 << WK_EIS) | ((1 << NPIN) - 1));
  localparam logic [DW-1:0] MASK_W = DW'((1 << MK_GIE) | (1 << MK_EXT) | (1 << MK_TMR));
  localparam logic [DW-1:0] FLAG_W = DW'((1 << FL_EXT) | (1 << FL_TMR));

  logic [DW-1:0] wake_q, wake_d, mask_q, mask_d, flag_q, flag_d, spend_q, spend_d;
  logic [DW-1:0] set_bits, keep_bits, drop_bits;
  logic          wr_wake, wr_mask, wr_flag, ext_set;

  always_comb begin
    wr_wake = sw_wr_en && (reg_sel_e'(sw_sel) == SEL_WAKE);
    wr_mask = sw_wr_en && (reg_sel_e'(sw_sel) == SEL_MASK);
    wr_flag = sw_wr_en && (reg_sel_e'(sw_sel) == SEL_FLAG);

    wake_d = wr_wake ? (sw_wdata & WAKE_W) : wake_q;

    mask_d = wr_mask ? (sw_wdata & MASK_W) : mask_q;
    if (irq_ack)   mask_d[MK_GIE] = 1'b0;
    else if (reti) mask_d[MK_GIE] = 1'b1;

    ext_set  = pin_fall[0] & wake_q[WK_EIS] & wake_q[0];
    set_bits = '0;
    set_bits[FL_EXT] = ext_set;
    set_bits[FL_TMR] = tmr_ovf;
    keep_bits = wr_flag ? sw_wdata : '1;
    drop_bits = warm_wake ? spend_q : '0;
    flag_d    = (((flag_q & keep_bits) | set_bits) & ~drop_bits) & FLAG_W;
    spend_d   = (asleep && !warm_wake) ? ((spend_q | set_bits) & flag_d) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
      spend_q <= '0;
    end else begin
      wake_q  <= wake_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      spend_q <= spend_d;
    end
  end

  always_comb begin
    case (reg_sel_e'(sw_sel))
      SEL_WAKE: sw_rdata = wake_q;
      SEL_MASK: sw_rdata = mask_q;
      SEL_FLAG: sw_rdata = flag_q;
      default:  sw_rdata = '0;
    endcase
  end

  assign wdt_run  = cfg_wdt_en & wake_q[WK_WDT];
  assign wake_req = asleep & wake_q[WK_WUE] & (|(pin_fall & wake_q[NPIN-1:0]));
  assign irq_req  = adv_mode & mask_q[MK_GIE] & ~asleep &
                    ((flag_q[FL_EXT] & mask_q[MK_EXT]) | (flag_q[FL_TMR] & mask_q[MK_TMR]));

  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !mask_q[MK_GIE]);
  // R9
  reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> mask_q[MK_GIE]);
  // R6
  tmr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FL_TMR]) |-> $past(tmr_ovf));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flag_q[FL_TMR]);
  // R5
  ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FL_EXT]) |-> $past(pin_fall[0] && wake_q[WK_EIS] && wake_q[0]));
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int           NPIN    = 4,
  parameter int           DW      = 8,
  parameter int           PCW     = 11,
  parameter logic [PCW-1:0] IRQ_VEC = 11'h7FE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_mode,
  input  logic            cfg_wdt_en,
  input  logic            asleep,
  input  logic [NPIN-1:0] pin_a,
  input  logic            tmr_ovf,
  input  logic            irq_ack,
  input  logic            reti,
  input  logic            warm_wake,
  input  logic            sw_wr_en,
  input  logic [1:0]      sw_sel,
  input  logic [DW-1:0]   sw_wdata,
  output logic [DW-1:0]   sw_rdata,
  output logic            irq_req,
  output logic [PCW-1:0]  irq_vector,
  output logic            wake_req,
  output logic            wdt_run
);
  logic [NPIN-1:0] pin_fall;

  pin_fall_det #(.NPIN(NPIN)) u_fall (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_a), .fall_o(pin_fall)
  );

  irq_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .adv_mode(adv_mode), .cfg_wdt_en(cfg_wdt_en),
    .asleep(asleep), .pin_fall(pin_fall), .tmr_ovf(tmr_ovf), .irq_ack(irq_ack),
    .reti(reti), .warm_wake(warm_wake), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .irq_req(irq_req),
    .wake_req(wake_req), .wdt_run(wdt_run)
  );

  assign irq_vector = IRQ_VEC;
endmodule

// File: tb/irq_wake_ctrl_tb.sv
`timescale 1ns/1ps
module irq_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, adv_mode, cfg_wdt_en, asleep, tmr_ovf, irq_ack, reti, warm_wake, sw_wr_en;
  logic [3:0] pin_a;
  logic [1:0] sw_sel;
  logic [7:0] sw_wdata, sw_rdata;
  logic irq_req, wake_req, wdt_run;
  logic [10:0] irq_vector;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .adv_mode(adv_mode), .cfg_wdt_en(cfg_wdt_en),
    .asleep(asleep), .pin_a(pin_a), .tmr_ovf(tmr_ovf), .irq_ack(irq_ack),
    .reti(reti), .warm_wake(warm_wake), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .irq_req(irq_req),
    .irq_vector(irq_vector), .wake_req(wake_req), .wdt_run(wdt_run)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    sw_sel = sel;
    #1 d = sw_rdata;
  endtask

  task automatic tmr_pulse();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic fall_pin(input int n, output int pulses);
    pulses = 0;
    @(negedge clk); pin_a[n] = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (wake_req) pulses++;
    end
    pin_a[n] = 1'b1;
    cyc(4);
  endtask

  task automatic set_both();
    int p;
    wr(2'd0, 8'h21);
    tmr_pulse();
    fall_pin(0, p);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int p;
    rst_n = 1'b0; adv_mode = 1'b0; cfg_wdt_en = 1'b0; asleep = 1'b0; tmr_ovf = 1'b0;
    irq_ack = 1'b0; reti = 1'b0; warm_wake = 1'b0; sw_wr_en = 1'b0; sw_sel = 2'd0;
    sw_wdata = 8'h00; pin_a = 4'hF;
    cyc(3); rst_n = 1'b1; cyc(4);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin rd(s[1:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq_req", irq_req, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 wdt_run", wdt_run, 0);
    chk("R8 vector", irq_vector, 11'h7FE);

    // R2 write masks
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 wake mask", d, 8'hEF);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 intmask mask", d, 8'h85);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 none", d, 0);
    wr(2'd1, 8'h00); rd(2'd1, d); chk("R2 intmask clr", d, 0);

    // R3 watchdog enable
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++) begin
        cfg_wdt_en = c[0];
        wr(2'd0, w[0] ? 8'h80 : 8'h00);
        #1 chk("R3 wdt_run", wdt_run, c & w);
      end
    cfg_wdt_en = 1'b0;

    // R4 R5 exhaustive pin sweep while asleep
    asleep = 1'b1;
    for (int n = 0; n < 4; n++)
      for (int en = 0; en < 16; en++)
        for (int wue = 0; wue < 2; wue++)
          for (int eis = 0; eis < 2; eis++) begin
            wr(2'd0, 8'((wue << 6) | (eis << 5) | en));
            fall_pin(n, p);
            chk("R4 wake pulses", p, wue & ((en >> n) & 1));
            rd(2'd2, d);
            chk("R5 ext flag", d, ((n == 0) && eis && (en & 1)) ? 8'h04 : 8'h00);
            wr(2'd2, 8'h00);
          end
    asleep = 1'b0;

    // R6 R7 timer flag
    tmr_pulse(); rd(2'd2, d); chk("R6 tmr flag", d, 8'h01);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R7 write1 keeps", d, 8'h01);
    wr(2'd2, 8'h00); rd(2'd2, d); chk("R7 write0 clears", d, 8'h00);
    wr(2'd2, 8'h05); rd(2'd2, d); chk("R7 write1 no set", d, 8'h00);
    @(negedge clk); tmr_ovf = 1'b1; sw_wr_en = 1'b1; sw_sel = 2'd2; sw_wdata = 8'h00;
    @(negedge clk); tmr_ovf = 1'b0; sw_wr_en = 1'b0;
    rd(2'd2, d); chk("R7 set wins", d, 8'h01);
    wr(2'd2, 8'h00);

    // R8 request sweep
    for (int f = 0; f < 4; f++) begin
      set_both();
      wr(2'd2, 8'(((f >> 1) << 2) | (f & 1)));
      for (int a = 0; a < 2; a++)
        for (int m = 0; m < 8; m++) begin
          adv_mode = a[0];
          wr(2'd1, 8'(((m >> 2) << 7) | (((m >> 1) & 1) << 2) | (m & 1)));
          #1 chk("R8 irq_req", irq_req,
                 a & (m >> 2) & ((((m >> 1) & 1) & (f >> 1)) | ((m & 1) & (f & 1))));
        end
      wr(2'd2, 8'h00);
    end

    // R9 acknowledge and return
    adv_mode = 1'b1;
    tmr_pulse(); wr(2'd1, 8'h81); #1 chk("R9 req before ack", irq_req, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(2'd1, d); chk("R9 ack clears gie", d, 8'h01);
    chk("R9 no request after ack", irq_req, 0);
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
    rd(2'd1, d); chk("R9 reti sets gie", d, 8'h81);
    wr(2'd2, 8'h00);

    // R10 sleep interplay
    wr(2'd0, 8'h62);
    asleep = 1'b1;
    tmr_pulse(); #1 chk("R10 no request asleep", irq_req, 0);
    fall_pin(1, p); chk("R10 pin wake", p, 1);
    asleep = 1'b0; #1;
    rd(2'd2, d); chk("R10 survives pin wake", d, 8'h01);
    chk("R10 request after wake", irq_req, 1);
    wr(2'd2, 8'h00);
    asleep = 1'b1;
    tmr_pulse();
    @(negedge clk); warm_wake = 1'b1;
    @(negedge clk); warm_wake = 1'b0; asleep = 1'b0;
    rd(2'd2, d); chk("R10 warm drops", d, 8'h00);
    set_both(); wr(2'd2, 8'h04);
    asleep = 1'b1;
    tmr_pulse();
    @(negedge clk); warm_wake = 1'b1;
    @(negedge clk); warm_wake = 1'b0; asleep = 1'b0;
    rd(2'd2, d); chk("R10 pre-sleep kept", d, 8'h04);

    summary();
  end
endmodule